// File: doc/BRIEF.md
# Video DAC Level Encoding Pipeline

This block is the digital front end of a three-channel video DAC. On every rising clock edge it captures three 8-bit colour samples (red, green, blue) together with three video controls: a force-to-white request, an active-low sync and an active-low blank. It also captures a configuration bit that says whether sync is carried on the green channel. Capturing everything on the same edge keeps the controls aligned with the pixel they belong to. One clock later it presents three drive codes in DAC LSB units. These codes can steer identical current-source arrays, because each pedestal level is already folded into the number.

The controls act in a fixed order. Blank wins over force-to-white, and force-to-white wins over the colour data. After that choice, a black pedestal is added to every unblanked channel. A sync pedestal is added to green while sync is inactive, but only when sync-on-green is enabled. Both pedestal sizes are parameters, with defaults of 21 LSB and 111 LSB. The code width is derived from the parameters, so with the defaults the codes are 9 bits wide.

Top module: `vdac_level_pipe`

## Requirements
- R1: Each output code reflects the inputs captured at the previous rising clock edge. A change on the inputs never reaches the outputs before that edge.
- R2: A synchronous active-high reset loads the blanked, sync-low state, so all three codes read 0 while reset is held and until new inputs are captured.
- R3: With blank_n low, red_code and blu_code are 0, whatever the colour data and force_white are.
- R4: With blank_n low, grn_code is the sync pedestal (111) when sync_n is high and sync_on_green is 1. Otherwise grn_code is 0.
- R5: With blank_n high and force_white high, every channel takes 255 as its data whatever its colour input, so red_code = blu_code = 276.
- R6: With blank_n high and force_white low, red_code and blu_code equal the channel's colour input plus 21.
- R7: With blank_n high, grn_code equals the selected green data plus 21, plus 111 when sync_n is high and sync_on_green is 1.
- R8: With sync_on_green at 0, grn_code follows the same rule as red and blue, and sync_n has no effect on any channel.
- R9: No code ever exceeds 387 (255 + 21 + 111), the largest value the 9-bit codes must hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock; inputs are captured on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sync_on_green | input | 1 | 1 adds the sync pedestal to green; 0 gives green the same range as red and blue |
| force_white | input | 1 | 1 forces the data of all channels to full scale while unblanked |
| sync_n | input | 1 | Active-low sync |
| blank_n | input | 1 | Active-low blank |
| red_in | input | 8 | Red colour sample |
| grn_in | input | 8 | Green colour sample |
| blu_in | input | 8 | Blue colour sample |
| red_code | output | 9 | Red drive code in LSB units |
| grn_code | output | 9 | Green drive code in LSB units |
| blu_code | output | 9 | Blue drive code in LSB units |

## Verification
Blank and force-to-white can be active in the same cycle, and sync can be active at the same time as either of them. In each such case the priority alone decides the codes. The bench walks all eight combinations of the three controls, with sync-on-green both on and off, using non-trivial colour data. It then mixes in random control and data patterns. Each result is compared against a bench model that applies blank before white and adds the pedestals last. The model's value is checked one cycle after capture, and the bench also checks that the outputs still hold the previous result just after new inputs are driven.

// File: rtl/vdac_pkg.sv
package vdac_pkg;

    localparam int NUM_CH       = 3;
    localparam int DEF_DATA_W   = 8;
    localparam int DEF_BLACK_PED = 21;
    localparam int DEF_SYNC_PED  = 111;

    typedef enum logic [1:0] {
        CH_RED = 2'd0,
        CH_GRN = 2'd1,
        CH_BLU = 2'd2
    } chan_e;

    typedef struct packed {
        logic sog;
        logic force_white;
        logic sync_n;
        logic blank_n;
    } vid_ctrl_t;

    localparam vid_ctrl_t CTRL_IDLE = '{sog: 1'b0, force_white: 1'b0,
                                        sync_n: 1'b0, blank_n: 1'b0};

    function automatic int max_code(input int dw, input int black, input int sync);
        return (2 ** dw) - 1 + black + sync;
    endfunction

    function automatic int code_width(input int dw, input int black, input int sync);
        return $clog2(max_code(dw, black, sync) + 1);
    endfunction

endpackage

// File: rtl/vdac_capture.sv
module vdac_capture
    import vdac_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  vid_ctrl_t                      ctrl_in,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  data_in,
    output vid_ctrl_t                      ctrl_q,
    output logic [NUM_CH-1:0][DATA_W-1:0]  data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_IDLE;
            data_q <= '0;
        end else begin
            ctrl_q <= ctrl_in;
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/vdac_chan_enc.sv
module vdac_chan_enc
    import vdac_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int BLACK_PED  = DEF_BLACK_PED,
    parameter int SYNC_PED   = DEF_SYNC_PED,
    parameter int CODE_W     = code_width(DATA_W, BLACK_PED, SYNC_PED),
    parameter bit IS_SYNC_CH = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  vid_ctrl_t         ctrl,
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] BLACK_C = CODE_W'(BLACK_PED);
    localparam logic [CODE_W-1:0] SYNC_C  = CODE_W'(SYNC_PED);
    localparam int                MAX_C   = max_code(DATA_W, BLACK_PED, SYNC_PED);
    localparam int                WHITE_C = (2 ** DATA_W) - 1 + BLACK_PED;

    logic [DATA_W-1:0] data_sel;
    logic [CODE_W-1:0] video_part;
    logic [CODE_W-1:0] sync_part;
    logic              sync_on;

    // priority: blank over white over data
    always_comb begin
        data_sel = ctrl.force_white ? {DATA_W{1'b1}} : data;
        video_part = ctrl.blank_n ? (CODE_W'(data_sel) + BLACK_C) : '0;
    end

    generate
        if (IS_SYNC_CH) begin : g_sync
            assign sync_on = ctrl.sog & ctrl.sync_n;
        end else begin : g_nosync
            assign sync_on = 1'b0;
        end
    endgenerate

    assign sync_part = sync_on ? SYNC_C : '0;
    assign code      = video_part + sync_part;

    assert_code_range_R9: assert property (@(posedge clk) disable iff (rst)
        int'(code) <= MAX_C);

    assert_flat_range_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.sog && ctrl.blank_n) |-> (int'(code) >= BLACK_PED && int'(code) <= WHITE_C));

endmodule

// File: rtl/vdac_level_pipe.sv
module vdac_level_pipe
    import vdac_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int BLACK_PED = DEF_BLACK_PED,
    parameter int SYNC_PED  = DEF_SYNC_PED,
    parameter int CODE_W    = code_width(DATA_W, BLACK_PED, SYNC_PED)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_on_green,
    input  logic              force_white,
    input  logic              sync_n,
    input  logic              blank_n,
    input  logic [DATA_W-1:0] red_in,
    input  logic [DATA_W-1:0] grn_in,
    input  logic [DATA_W-1:0] blu_in,
    output logic [CODE_W-1:0] red_code,
    output logic [CODE_W-1:0] grn_code,
    output logic [CODE_W-1:0] blu_code
);

    localparam int WHITE_C = (2 ** DATA_W) - 1 + BLACK_PED;

    vid_ctrl_t                     ctrl_in;
    vid_ctrl_t                     ctrl_q;
    logic [NUM_CH-1:0][DATA_W-1:0] data_in;
    logic [NUM_CH-1:0][DATA_W-1:0] data_q;
    logic [NUM_CH-1:0][CODE_W-1:0] codes;

    always_comb begin
        ctrl_in.sog         = sync_on_green;
        ctrl_in.force_white = force_white;
        ctrl_in.sync_n      = sync_n;
        ctrl_in.blank_n     = blank_n;
        data_in[CH_RED]     = red_in;
        data_in[CH_GRN]     = grn_in;
        data_in[CH_BLU]     = blu_in;
    end

    vdac_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .ctrl_in (ctrl_in),
        .data_in (data_in),
        .ctrl_q  (ctrl_q),
        .data_q  (data_q)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        vdac_chan_enc #(
            .DATA_W     (DATA_W),
            .BLACK_PED  (BLACK_PED),
            .SYNC_PED   (SYNC_PED),
            .CODE_W     (CODE_W),
            .IS_SYNC_CH (ch == int'(CH_GRN))
        ) u_enc (
            .clk  (clk),
            .rst  (rst),
            .ctrl (ctrl_q),
            .data (data_q[ch]),
            .code (codes[ch])
        );
    end

    assign red_code = codes[CH_RED];
    assign grn_code = codes[CH_GRN];
    assign blu_code = codes[CH_BLU];

    assert_reset_zero_R2: assert property (@(posedge clk)
        $past(rst) |-> (red_code == '0 && grn_code == '0 && blu_code == '0));

    assert_blank_rb_R3: assert property (@(posedge clk) disable iff (rst)
        $past(!blank_n && !rst) |-> (red_code == '0 && blu_code == '0));

    assert_blank_green_R4: assert property (@(posedge clk) disable iff (rst)
        $past(!blank_n && !rst) |->
            (grn_code == ($past(sync_n && sync_on_green) ? CODE_W'(SYNC_PED) : '0)));

    assert_white_R5: assert property (@(posedge clk) disable iff (rst)
        $past(blank_n && force_white && !rst) |->
            (int'(red_code) == WHITE_C && int'(blu_code) == WHITE_C));

    assert_red_data_R6: assert property (@(posedge clk) disable iff (rst)
        $past(blank_n && !force_white && !rst) |->
            (int'(red_code) == int'($past(red_in)) + BLACK_PED));

endmodule

// File: tb/vdac_level_pipe_tb.sv
module vdac_level_pipe_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sog = 1'b0;
    logic       fw = 1'b0;
    logic       sync_n = 1'b0;
    logic       blank_n = 1'b0;
    logic [7:0] r_in = '0;
    logic [7:0] g_in = '0;
    logic [7:0] b_in = '0;
    logic [8:0] r_code;
    logic [8:0] g_code;
    logic [8:0] b_code;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int prev_r = 0;
    int prev_g = 0;
    int prev_b = 0;

    always #4 clk = ~clk;

    vdac_level_pipe dut_i (
        .clk           (clk),
        .rst           (rst),
        .sync_on_green (sog),
        .force_white   (fw),
        .sync_n        (sync_n),
        .blank_n       (blank_n),
        .red_in        (r_in),
        .grn_in        (g_in),
        .blu_in        (b_in),
        .red_code      (r_code),
        .grn_code      (g_code),
        .blu_code      (b_code)
    );

    // model: blank > white > data, then pedestals
    function automatic int model(input bit green, input int d, input bit w,
                                 input bit s, input bit b, input bit so);
        int v;
        v = 0;
        if (b) v = (w ? 255 : d) + 21;
        if (green && s && so) v = v + 111;
        return v;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic string rule_tag(input bit w, input bit s, input bit b, input bit so);
        if (!b) return "R3_R4";
        if (!so) return "R8";
        if (w) return "R5";
        if (s) return "R7";
        return "R6";
    endfunction

    task automatic apply(input bit so, input bit w, input bit s, input bit b,
                         input logic [7:0] rd, input logic [7:0] gd, input logic [7:0] bd);
        int er, eg, eb;
        string tag;
        @(negedge clk);
        sog = so; fw = w; sync_n = s; blank_n = b;
        r_in = rd; g_in = gd; b_in = bd;
        #1;
        chk("R1", "red held", int'(r_code), prev_r);
        chk("R1", "green held", int'(g_code), prev_g);
        chk("R1", "blue held", int'(b_code), prev_b);
        er = model(1'b0, int'(rd), w, s, b, so);
        eg = model(1'b1, int'(gd), w, s, b, so);
        eb = model(1'b0, int'(bd), w, s, b, so);
        tag = rule_tag(w, s, b, so);
        @(negedge clk);
        chk(tag, "red", int'(r_code), er);
        chk(tag, "green", int'(g_code), eg);
        chk(tag, "blue", int'(b_code), eb);
        chk("R9", "green range", (int'(g_code) <= 387) ? 1 : 0, 1);
        prev_r = er; prev_g = eg; prev_b = eb;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd1994);
        // R2: reset dominates live unblanked white inputs
        sog = 1'b1; fw = 1'b1; sync_n = 1'b1; blank_n = 1'b1;
        r_in = 8'h5A; g_in = 8'hA5; b_in = 8'h3C;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2", "red", int'(r_code), 0);
        chk("R2", "green", int'(g_code), 0);
        chk("R2", "blue", int'(b_code), 0);
        rst = 1'b0;
        sog = 1'b0; fw = 1'b0; sync_n = 1'b0; blank_n = 1'b0;
        r_in = '0; g_in = '0; b_in = '0;

        // every control combination, sync-on-green on and off
        for (int so = 0; so < 2; so++)
            for (int k = 0; k < 8; k++)
                apply(so[0], k[2], k[1], k[0], 8'h37, 8'hC4, 8'h81);

        // boundary data values
        apply(1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF);   // R7 max green 387
        apply(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00);   // R6 black level
        apply(1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'h00);   // R8 flat green
        apply(1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 8'hFF, 8'hFF);   // R3 R4 white ignored under blank
        apply(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h12, 8'h00);   // R5 forced white

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            apply(rv[0], rv[1], rv[2], rv[3] | rv[4], rv[15:8], rv[23:16], rv[31:24]);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule